// File: doc/BRIEF.md
# Host Bus to Word Register Bridge

This block lets an external 16-bit asynchronous microprocessor bus reach an internal space of 32-bit registers and memories. A static mode pin selects one of two bus protocols. In the first, a chip select and a data strobe open the cycle and a read/write level sets its direction. In the second, separate read and write strobes do both. Every host strobe passes through a two-flop synchroniser before the block acts on it. The block ends each cycle with two outputs: a wait indication while internal data is not ready, and an active-low data acknowledge once the access is done.

Each 32-bit word spans four byte addresses, and the lowest address names the most significant byte. The host pins carry byte address bits AW-1 down to 1. Address bit 1 selects the upper or lower 16-bit half of the word. Each data line k serves word bit k+16 or word bit k. An upper-half write is staged and commits nothing. The lower-half write then commits the whole word in one internal write. An upper-half read captures the whole word, so the lower-half read that follows sees a consistent value. Words at or above a parameterised base form a read-only data memory, and host writes to them never reach the internal side.

Top module: `hbus_bridge`

## Requirements
- R1: With mode_intel_i=0, a cycle opens when cs_ni and rd_ds_ni are both low, and wr_rw_i high means read while low means write. With mode_intel_i=1, a cycle opens when cs_ni is low and either rd_ds_ni (read) or wr_rw_i (write) is low.
- R2: With mode_intel_i=0, wr_rw_i low with cs_ni low but rd_ds_ni high opens no cycle. wait_o stays 0, dta_no stays 1 and reg_we_o stays 0.
- R3: wait_o is 1 from the moment a valid strobe is applied until the access completes, and it is never 1 while dta_no is 0.
- R4: dta_no falls on the (ACC_LAT+3)-th rising clock edge after the strobe is applied (5 with defaults). It stays low until the strobe is removed and then returns high.
- R5: The word address is addr_i[AW-1:2]. addr_i[1]=0 selects word bits 31:16 and addr_i[1]=1 selects bits 15:0. data_i[k] and data_o[k] map to word bit k+16 or k.
- R6: An upper-half write only loads a staging register. A lower-half write issues exactly one single-cycle reg_we_o with reg_wdata_o = {staged value, data_i}. The staged value resets to 0 and persists after a commit.
- R7: An upper-half read captures the whole word. The next lower-half read of that same word returns the captured low half, even if the word changed in between. Any other lower-half read returns the current low half. Every lower-half read consumes the capture.
- R8: Words at addresses >= RO_BASE_W are read-only. Writes to them never assert reg_we_o, and reads of them return their contents.
- R9: After reset wait_o=0, dta_no=1, data_oe_o=0 and reg_we_o=0. data_oe_o is 1 only while dta_no is low during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_intel_i | input | 1 | Static protocol select: 0 strobe plus read/write level, 1 separate read and write strobes |
| cs_ni | input | 1 | Chip select, active low |
| rd_ds_ni | input | 1 | Data strobe (mode 0) or read strobe (mode 1), active low |
| wr_rw_i | input | 1 | Read/write level (mode 0, low = write) or write strobe (mode 1, active low) |
| addr_i | input | AW-1 | Byte address bits AW-1..1 |
| data_i | input | 16 | Write data from host |
| data_o | output | 16 | Read data to host |
| data_oe_o | output | 1 | Drive enable for data_o |
| wait_o | output | 1 | Access not yet complete |
| dta_no | output | 1 | Data acknowledge, active low |
| reg_addr_o | output | AW-2 | Internal word address |
| reg_rd_o | output | 1 | Internal read in progress |
| reg_we_o | output | 1 | Internal word write, one cycle |
| reg_wdata_o | output | 32 | Internal write data |
| reg_rdata_i | input | 32 | Internal read data for reg_addr_o |

## Verification
The assertions check the cycle-level rules on every clock. Wait and acknowledge are never active together. The write enable is a single pulse followed by the acknowledge. The read-only region never sees a write. Internal read and write never overlap. The output enable appears only inside the acknowledge. Only the bench scenarios show the end-to-end behaviour: the exact acknowledge latency through the synchroniser, the lane mapping, staged commits, and the capture returned by a lower-half read after the word has changed behind the host's back. The bench also confirms that the first protocol ignores a write level without a data strobe, and it compares random mixes of both protocols against a reference model.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ACK  = 2'd2
  } hb_state_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= 2'b00;
      else         ff_q <= {ff_q[0], d_i[g]};
    end
    assign q_o[g] = ff_q[1];
  end
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode (
  input  logic mode_intel_i,
  input  logic cs_ni,
  input  logic rd_ds_ni,
  input  logic wr_rw_i,
  output logic strobe_o,
  output logic is_wr_o
);
  // both protocols: wr_rw_i low means write
  always_comb begin
    if (mode_intel_i) strobe_o = !cs_ni && (!rd_ds_ni || !wr_rw_i);
    else              strobe_o = !cs_ni && !rd_ds_ni;
    is_wr_o = !wr_rw_i;
  end
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int ACC_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic wr_i,
  output logic busy_o,
  output logic fire_o,
  output logic ack_o,
  output logic wr_o
);
  localparam int CW = $clog2(ACC_LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(ACC_LAT - 1);

  hb_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (act_i) begin
          state_q <= ST_BUSY;
          cnt_q   <= '0;
          wr_q    <= wr_i;
        end
        ST_BUSY: begin
          if (cnt_q == LAST) state_q <= ST_ACK;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_ACK: if (!act_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_BUSY);
  assign fire_o = busy_o && (cnt_q == LAST);
  assign ack_o  = (state_q == ST_ACK);
  assign wr_o   = wr_q;
endmodule

// File: rtl/hbus_lanes.sv
module hbus_lanes #(
  parameter int AW        = 12,
  parameter int RO_BASE_W = 768
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          wr_i,
  input  logic [AW-1:1] addr_i,
  input  logic [15:0]   data_i,
  input  logic [31:0]   rdata_i,
  output logic          we_o,
  output logic [31:0]   wdata_o,
  output logic [15:0]   rd_o
);
  localparam int WAW = AW - 2;
  localparam logic [WAW-1:0] RO_W = WAW'(RO_BASE_W);

  logic [WAW-1:0] word;
  logic           half_lo, ro;
  logic [15:0]    stage_q, cap_q, rd_q;
  logic [WAW-1:0] cap_a_q;
  logic           cap_v_q;

  assign word    = addr_i[AW-1:2];
  assign half_lo = addr_i[1];
  assign ro      = (word >= RO_W);

  assign we_o    = fire_i && wr_i && half_lo && !ro;
  assign wdata_o = {stage_q, data_i};
  assign rd_o    = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      cap_q   <= '0;
      cap_a_q <= '0;
      cap_v_q <= 1'b0;
      rd_q    <= '0;
    end else if (fire_i) begin
      if (wr_i) begin
        if (!half_lo) stage_q <= data_i;
      end else if (!half_lo) begin
        rd_q    <= rdata_i[31:16];
        cap_q   <= rdata_i[15:0];
        cap_a_q <= word;
        cap_v_q <= 1'b1;
      end else begin
        rd_q    <= (cap_v_q && cap_a_q == word) ? cap_q : rdata_i[15:0];
        cap_v_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hbus_bridge.sv
module hbus_bridge #(
  parameter int AW        = 12,
  parameter int ACC_LAT   = 2,
  parameter int RO_BASE_W = 768
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_intel_i,
  input  logic          cs_ni,
  input  logic          rd_ds_ni,
  input  logic          wr_rw_i,
  input  logic [AW-1:1] addr_i,
  input  logic [15:0]   data_i,
  output logic [15:0]   data_o,
  output logic          data_oe_o,
  output logic          wait_o,
  output logic          dta_no,
  output logic [AW-3:0] reg_addr_o,
  output logic          reg_rd_o,
  output logic          reg_we_o,
  output logic [31:0]   reg_wdata_o,
  input  logic [31:0]   reg_rdata_i
);
  logic strobe_raw, wr_raw;
  logic [1:0] sync_q;
  logic busy, fire, ack, wr_q;

  hbus_decode u_dec (
    .mode_intel_i(mode_intel_i),
    .cs_ni       (cs_ni),
    .rd_ds_ni    (rd_ds_ni),
    .wr_rw_i     (wr_rw_i),
    .strobe_o    (strobe_raw),
    .is_wr_o     (wr_raw)
  );

  hbus_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_raw, strobe_raw}),
    .q_o   (sync_q)
  );

  hbus_ctrl #(.ACC_LAT(ACC_LAT)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (sync_q[0]),
    .wr_i  (sync_q[1]),
    .busy_o(busy),
    .fire_o(fire),
    .ack_o (ack),
    .wr_o  (wr_q)
  );

  hbus_lanes #(.AW(AW), .RO_BASE_W(RO_BASE_W)) u_lanes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .wr_i   (wr_q),
    .addr_i (addr_i),
    .data_i (data_i),
    .rdata_i(reg_rdata_i),
    .we_o   (reg_we_o),
    .wdata_o(reg_wdata_o),
    .rd_o   (data_o)
  );

  // wait follows the raw strobe so the host sees it without sync delay
  assign wait_o     = strobe_raw && !ack;
  assign dta_no     = !ack;
  assign data_oe_o  = ack && !wr_q;
  assign reg_rd_o   = busy && !wr_q;
  assign reg_addr_o = addr_i[AW-1:2];
endmodule

// File: rtl/hbus_bridge_chk.sv
module hbus_bridge_chk #(
  parameter int AW        = 12,
  parameter int RO_BASE_W = 768
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wait_o,
  input logic          dta_no,
  input logic          data_oe_o,
  input logic          reg_rd_o,
  input logic          reg_we_o,
  input logic [AW-3:0] reg_addr_o
);
  localparam logic [AW-3:0] RO_W = (AW-2)'(RO_BASE_W);

  a_r3_no_wait_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dta_no |-> !wait_o);

  a_r6_we_single_then_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> (!reg_we_o && !dta_no));

  a_r6_rd_we_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_we_o));

  a_r8_no_ro_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_addr_o < RO_W));

  a_r9_oe_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !dta_no);
endmodule

bind hbus_bridge hbus_bridge_chk #(.AW(AW), .RO_BASE_W(RO_BASE_W)) chk_i (.*);

// File: tb/hbus_bridge_tb_top.sv
module hbus_bridge_tb_top;
  localparam int AW = 12, ACC_LAT = 2, RO_BASE_W = 768;
  localparam int NW = 1 << (AW - 2);
  localparam int EXP_LAT = ACC_LAT + 3;

  logic clk = 0, rst_n = 0;
  logic mode_intel = 0, cs_n = 1, rd_ds_n = 1, wr_rw = 1;
  logic [AW-1:1] addr = '0;
  logic [15:0] din = '0, dout;
  logic oe, wt, dta_n, reg_rd, reg_we;
  logic [AW-3:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  hbus_bridge #(.AW(AW), .ACC_LAT(ACC_LAT), .RO_BASE_W(RO_BASE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_intel_i(mode_intel), .cs_ni(cs_n),
    .rd_ds_ni(rd_ds_n), .wr_rw_i(wr_rw), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .wait_o(wt), .dta_no(dta_n),
    .reg_addr_o(reg_addr), .reg_rd_o(reg_rd), .reg_we_o(reg_we),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  logic [31:0] mem [NW];
  logic [31:0] exp_mem [NW];
  int we_cnt = 0;
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) begin mem[reg_addr] = reg_wdata; we_cnt++; end

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] stg_m = '0, cap_d_m = '0;
  int cap_a_m = 0;
  bit cap_v_m = 0;

  function automatic logic [31:0] ro_pat(int w);
    return 32'h5A00_0000 ^ (32'(w) * 32'h9E37_79B1);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one host cycle with model update and checks
  task automatic op(input bit wr, input int w, input bit lo, input logic [15:0] d, input string req);
    int lat = 0;
    int k;
    logic [15:0] exp_d;
    @(negedge clk);
    addr = {w[AW-3:0], lo};
    din = d;
    wr_rw = !wr;
    rd_ds_n = (mode_intel && wr) ? 1'b1 : 1'b0;
    cs_n = 0;
    #1 chk("R3", "wait at start", 32'(wt), 32'd1);
    while (lat < 40) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (!dta_n) break;
    end
    chk("R4", "ack latency", lat, EXP_LAT);
    chk("R3", "wait at ack", 32'(wt), 32'd0);
    chk("R9", "oe during ack", 32'(oe), 32'(!wr));
    if (!wr) begin
      if (!lo) begin
        exp_d = exp_mem[w][31:16];
        cap_v_m = 1; cap_a_m = w; cap_d_m = exp_mem[w][15:0];
      end else begin
        exp_d = (cap_v_m && cap_a_m == w) ? cap_d_m : exp_mem[w][15:0];
        cap_v_m = 0;
      end
      chk(req, "read data", 32'(dout), 32'(exp_d));
    end else if (!lo) begin
      stg_m = d;
    end else if (w < RO_BASE_W) begin
      exp_mem[w] = {stg_m, d};
    end
    cs_n = 1; rd_ds_n = 1; wr_rw = 1;
    k = 0;
    while (dta_n !== 1'b1 && k < 20) begin @(negedge clk); k++; end
    chk("R4", "ack released", 32'(dta_n), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
    end
  end

  initial begin
    int we0;
    void'($urandom(32'd4711));
    for (int w = 0; w < NW; w++) begin
      mem[w] = (w >= RO_BASE_W) ? ro_pat(w) : 32'h0;
      exp_mem[w] = mem[w];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "reset wait", 32'(wt), 0);
    chk("R9", "reset dta", 32'(dta_n), 1);
    chk("R9", "reset oe", 32'(oe), 0);
    chk("R9", "reset we", 32'(reg_we), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1/R5/R6: mode 0 staged write then halves
    mode_intel = 0;
    we0 = we_cnt;
    op(1, 5, 0, 16'h8001, "R6");
    chk("R6", "no write on upper half", we_cnt - we0, 0);
    op(0, 5, 1, 16'h0, "R6");
    op(1, 5, 1, 16'h0180, "R6");
    chk("R6", "one write on lower half", we_cnt - we0, 1);
    chk("R5", "committed word", mem[5], 32'h8001_0180);
    op(0, 5, 0, 16'h0, "R5");
    op(0, 5, 1, 16'h0, "R5");

    // R1 intel protocol, R6 stage persists
    mode_intel = 1;
    op(1, 9, 1, 16'h1234, "R1");
    chk("R6", "persisting stage", mem[9], 32'h8001_1234);
    op(1, 10, 0, 16'hBEEF, "R1");
    op(1, 10, 1, 16'hCAFE, "R1");
    op(0, 10, 0, 16'h0, "R1");
    op(0, 10, 1, 16'h0, "R1");

    // R7 capture survives a change behind the host
    op(0, 10, 0, 16'h0, "R7");
    mem[10] = 32'h1111_2222; exp_mem[10] = 32'h1111_2222;
    op(0, 10, 1, 16'h0, "R7");
    op(0, 10, 1, 16'h0, "R7");
    op(0, 9, 0, 16'h0, "R7");
    op(0, 10, 1, 16'h0, "R7");

    // R8 read-only region
    we0 = we_cnt;
    op(1, 800, 0, 16'hFFFF, "R8");
    op(1, 800, 1, 16'hFFFF, "R8");
    chk("R8", "no write to read-only", we_cnt - we0, 0);
    op(0, 800, 0, 16'h0, "R8");
    op(0, 800, 1, 16'h0, "R8");

    // R2 write level without data strobe in mode 0
    mode_intel = 0;
    we0 = we_cnt;
    @(negedge clk);
    addr = '1; din = 16'h5555; wr_rw = 0; rd_ds_n = 1; cs_n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R2", "wait stays low", 32'(wt), 0);
      chk("R2", "dta stays high", 32'(dta_n), 1);
    end
    cs_n = 1; wr_rw = 1;
    chk("R2", "no internal write", we_cnt - we0, 0);
    repeat (4) @(negedge clk);

    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      int w;
      mode_intel = $urandom_range(0, 1);
      w = ($urandom_range(0, 9) < 7) ? $urandom_range(0, 7) : $urandom_range(0, NW - 1);
      if ($urandom_range(0, 1) == 1) w = (w < 4) ? RO_BASE_W + w : w;
      op($urandom_range(0, 1), w, $urandom_range(0, 1), 16'($urandom), "R5");
    end
    for (int w = 0; w < 8; w++) chk("R6", "final memory", mem[w], exp_mem[w]);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule